// File: doc/BRIEF.md
# Boot-time ROM shadowing bus controller

This controller owns the bus of an 8-bit CPU while the system comes out of reset. It generates the CPU phase clock one bus transfer at a time. It answers reads in a small bootstrap window and in the upper monitor region from images it holds internally. During the copy, writes aimed at the upper region go to system RAM. Any other read gets the no-operation filler opcode. The monitor image holds a reset vector that points into the bootstrap window, so after reset the CPU runs a copy loop. That loop reads the monitor bytes and writes them back into RAM at the same addresses.

The copy loop reports its progress by writing to two marker addresses, one when it starts and one when it has finished. Once the finish marker has been seen after the start marker, the controller gives the bus to the board's normal glue logic for good. From then on it stops answering reads and selecting RAM, and it drives the CPU clock as a free-running divided clock. Only an external reset brings it back to the boot phase.

Top module: `bsc_boot_shadow`

## Requirements
- R1: While `rst_n` is low, and for `HOLD_CYCLES` (default 4) clock cycles after it rises, `cpu_clk`, `glue_en`, `cpu_rdata_oe` and `ram_sel` are all low.
- R2: During boot, `cpu_clk` changes level on every `clk` rising edge, so each high phase lasts one `clk` cycle. That high phase is the single bus transfer of a CPU cycle.
- R3: During a boot high phase, a read (`cpu_rnw`=1) at `BOOT_BASE`+k, for k below `BOOT_DEPTH` (defaults 0x8000 and 64), drives `cpu_rdata_oe` high with the bootstrap byte (k*37+90) mod 256.
- R4: During a boot high phase, a read at address a ≥ `ROM_BASE` (default 0xE800) returns the monitor byte. That byte is a[7:0] XOR a[15:8], except that 0xFFFC returns the low byte of `BOOT_BASE` and 0xFFFD returns its high byte.
- R5: During a boot high phase, a read outside both windows returns 0xEA. The addresses just below `ROM_BASE` and just past the bootstrap window are included.
- R6: `ram_sel` is high only in a boot high phase with a write (`cpu_rnw`=0) at an address ≥ `ROM_BASE`. A write below `ROM_BASE` leaves both `ram_sel` and `cpu_rdata_oe` low. `cpu_rdata_oe` is never high during a write.
- R7: A write to `FINISH_MARK` (default 0x8889) has no effect unless a write to `START_MARK` (default 0x8888) has been seen since reset. In that case `glue_en` stays low and boot transfers continue.
- R8: A write to `FINISH_MARK` after the start marker raises `glue_en` from the next `clk` edge. `glue_en` then stays high until reset, whatever the later bus activity, including further marker writes.
- R9: While `glue_en` is high, `cpu_rdata_oe` and `ram_sel` stay low for every address and direction.
- R10: While `glue_en` is high, `cpu_clk` runs free, with each high and each low phase lasting exactly `RUN_DIV` (default 3) `clk` cycles.
- R11: Asserting `rst_n` while running drops `glue_en` and `cpu_clk` at once. After release, the boot sequence of R1 and R2 restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock from which the CPU clock is derived |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rnw | input | 1 | CPU read (1) / write (0) strobe |
| cpu_clk | output | 1 | CPU phase clock: stepped per transfer during boot, divided afterwards |
| cpu_rdata | output | 8 | Byte presented to the CPU during boot reads |
| cpu_rdata_oe | output | 1 | Drive enable for `cpu_rdata` onto the data bus |
| ram_sel | output | 1 | Routes the current boot write to system RAM |
| glue_en | output | 1 | Hands bus decoding to the board glue logic; sticky until reset |

## Verification
The hardest state to reach from the ports is the hand-over itself. It depends on a marker ordering, and it only takes effect on the clock edge that closes a transfer's high phase. The stimulus steps the CPU bus in time with the controller's own phase clock. It places each address during a low phase and samples during the following high phase. It first issues a premature finish marker to show that the marker is ignored, and only then issues the proper start-then-finish pair. After that it probes the run-mode outputs and measures the divided clock phase by phase before resetting from the running state.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_BOOT = 2'd1,
    ST_RUN  = 2'd2
  } bsc_state_e;

  localparam logic [7:0] NOP_FILL = 8'hEA;

  // Bootstrap image generator: byte at offset k of the bootstrap window.
  function automatic logic [7:0] boot_pattern(input int unsigned k);
    logic [7:0] kk;
    kk = k[7:0];
    return kk * 8'd37 + 8'd90;
  endfunction

  // Monitor image generator; the reset vector points at the bootstrap base.
  function automatic logic [7:0] mon_pattern(input logic [15:0] a,
                                             input logic [15:0] vec);
    if (a == 16'hFFFC) return vec[7:0];
    if (a == 16'hFFFD) return vec[15:8];
    return a[7:0] ^ a[15:8];
  endfunction

endpackage

// File: rtl/bsc_image.sv
module bsc_image #(
  parameter logic [15:0] BOOT_BASE  = 16'h8000,
  parameter int unsigned BOOT_DEPTH = 64
) (
  input  logic [15:0] addr,
  output logic [7:0]  boot_byte,
  output logic [7:0]  mon_byte
);
  localparam int unsigned AW = (BOOT_DEPTH > 1) ? $clog2(BOOT_DEPTH) : 1;

  logic [7:0]    boot_rom [BOOT_DEPTH];
  logic [AW-1:0] off;

  for (genvar g = 0; g < BOOT_DEPTH; g++) begin : g_rom
    assign boot_rom[g] = bsc_pkg::boot_pattern(g);
  end

  assign off       = AW'(addr - BOOT_BASE);
  assign boot_byte = boot_rom[off];
  assign mon_byte  = bsc_pkg::mon_pattern(addr, BOOT_BASE);
endmodule

// File: rtl/bsc_decode.sv
module bsc_decode #(
  parameter logic [15:0] BOOT_BASE   = 16'h8000,
  parameter int unsigned BOOT_DEPTH  = 64,
  parameter logic [15:0] ROM_BASE    = 16'hE800,
  parameter logic [15:0] START_MARK  = 16'h8888,
  parameter logic [15:0] FINISH_MARK = 16'h8889
) (
  input  logic        in_boot,
  input  logic        phi,
  input  logic [15:0] addr,
  input  logic        rnw,
  input  logic [7:0]  boot_byte,
  input  logic [7:0]  mon_byte,
  output logic [7:0]  rdata,
  output logic        rdata_oe,
  output logic        ram_sel,
  output logic        start_hit,
  output logic        finish_hit
);
  localparam logic [16:0] BOOT_END = 17'(BOOT_BASE) + 17'(BOOT_DEPTH);

  logic xfer, in_boot_win, in_rom_win;

  assign xfer        = in_boot && phi;
  assign in_boot_win = (addr >= BOOT_BASE) && ({1'b0, addr} < BOOT_END);
  assign in_rom_win  = (addr >= ROM_BASE);

  always_comb begin
    rdata = 8'h00;
    if (xfer && rnw) begin
      if (in_rom_win)       rdata = mon_byte;
      else if (in_boot_win) rdata = boot_byte;
      else                  rdata = bsc_pkg::NOP_FILL;
    end
  end

  assign rdata_oe   = xfer && rnw;
  assign ram_sel    = xfer && !rnw && in_rom_win;
  assign start_hit  = xfer && !rnw && (addr == START_MARK);
  assign finish_hit = xfer && !rnw && (addr == FINISH_MARK);
endmodule

// File: rtl/bsc_phase_gen.sv
module bsc_phase_gen #(
  parameter int unsigned RUN_DIV = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bsc_pkg::bsc_state_e   state,
  output logic                  phi
);
  localparam int unsigned CW = (RUN_DIV > 1) ? $clog2(RUN_DIV) : 1;
  localparam logic [CW-1:0] CMP = CW'(RUN_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi <= 1'b0;
      cnt <= '0;
    end else begin
      unique case (state)
        bsc_pkg::ST_BOOT: begin
          phi <= ~phi;
          cnt <= '0;
        end
        bsc_pkg::ST_RUN: begin
          if (cnt == CMP) begin
            cnt <= '0;
            phi <= ~phi;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phi <= 1'b0;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bsc_seq.sv
module bsc_seq #(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_hit,
  input  logic                finish_hit,
  output bsc_pkg::bsc_state_e state
);
  localparam int unsigned HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HOLD_CYCLES - 1);

  logic [HW-1:0] hold_cnt;
  logic          started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= bsc_pkg::ST_HOLD;
      hold_cnt <= '0;
      started  <= 1'b0;
    end else begin
      unique case (state)
        bsc_pkg::ST_HOLD: begin
          if (hold_cnt == HLAST) state <= bsc_pkg::ST_BOOT;
          else                   hold_cnt <= hold_cnt + 1'b1;
        end
        bsc_pkg::ST_BOOT: begin
          if (start_hit) started <= 1'b1;
          if (finish_hit && started) state <= bsc_pkg::ST_RUN;
        end
        default: state <= bsc_pkg::ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/bsc_boot_shadow.sv
module bsc_boot_shadow #(
  parameter logic [15:0] BOOT_BASE   = 16'h8000,
  parameter int unsigned BOOT_DEPTH  = 64,
  parameter logic [15:0] ROM_BASE    = 16'hE800,
  parameter logic [15:0] START_MARK  = 16'h8888,
  parameter logic [15:0] FINISH_MARK = 16'h8889,
  parameter int unsigned RUN_DIV     = 3,
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rnw,
  output logic        cpu_clk,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_rdata_oe,
  output logic        ram_sel,
  output logic        glue_en
);
  bsc_pkg::bsc_state_e state;
  logic [7:0] boot_byte, mon_byte;
  logic       start_hit, finish_hit;

  bsc_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_hit  (start_hit),
    .finish_hit (finish_hit),
    .state      (state)
  );

  bsc_phase_gen #(.RUN_DIV(RUN_DIV)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .phi   (cpu_clk)
  );

  bsc_image #(.BOOT_BASE(BOOT_BASE), .BOOT_DEPTH(BOOT_DEPTH)) u_image (
    .addr      (cpu_addr),
    .boot_byte (boot_byte),
    .mon_byte  (mon_byte)
  );

  bsc_decode #(
    .BOOT_BASE(BOOT_BASE), .BOOT_DEPTH(BOOT_DEPTH), .ROM_BASE(ROM_BASE),
    .START_MARK(START_MARK), .FINISH_MARK(FINISH_MARK)
  ) u_decode (
    .in_boot    (state == bsc_pkg::ST_BOOT),
    .phi        (cpu_clk),
    .addr       (cpu_addr),
    .rnw        (cpu_rnw),
    .boot_byte  (boot_byte),
    .mon_byte   (mon_byte),
    .rdata      (cpu_rdata),
    .rdata_oe   (cpu_rdata_oe),
    .ram_sel    (ram_sel),
    .start_hit  (start_hit),
    .finish_hit (finish_hit)
  );

  assign glue_en = (state == bsc_pkg::ST_RUN);
endmodule

// File: rtl/bsc_boot_shadow_chk.sv
module bsc_boot_shadow_chk #(
  parameter logic [15:0] ROM_BASE    = 16'hE800,
  parameter logic [15:0] FINISH_MARK = 16'h8889,
  parameter int unsigned RUN_DIV     = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rnw,
  input logic        cpu_clk,
  input logic        cpu_rdata_oe,
  input logic        ram_sel,
  input logic        glue_en
);
  logic        prev_clk;
  logic [15:0] streak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      streak   <= '0;
    end else begin
      prev_clk <= cpu_clk;
      if (cpu_clk != prev_clk) streak <= 16'd1;
      else if (streak != 16'hFFFF) streak <= streak + 16'd1;
    end
  end

  p_boot_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk && !glue_en) |=> !cpu_clk);

  p_sel_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (!cpu_rnw && cpu_clk && cpu_addr >= ROM_BASE));

  p_oe_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata_oe |-> (cpu_rnw && cpu_clk));

  p_handover_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glue_en) |-> ($past(cpu_addr) == FINISH_MARK && !$past(cpu_rnw) && $past(cpu_clk)));

  p_glue_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    glue_en |=> glue_en);

  p_run_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    glue_en |-> (!cpu_rdata_oe && !ram_sel));

  p_run_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    glue_en |-> (streak <= 16'(RUN_DIV)));
endmodule

bind bsc_boot_shadow bsc_boot_shadow_chk #(
  .ROM_BASE(ROM_BASE), .FINISH_MARK(FINISH_MARK), .RUN_DIV(RUN_DIV)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_addr     (cpu_addr),
  .cpu_rnw      (cpu_rnw),
  .cpu_clk      (cpu_clk),
  .cpu_rdata_oe (cpu_rdata_oe),
  .ram_sel      (ram_sel),
  .glue_en      (glue_en)
);

// File: tb/test_bsc_boot_shadow.sv
module test_bsc_boot_shadow;
  localparam int CLK_PERIOD  = 10;
  localparam int RUN_DIV     = 3;
  localparam int HOLD_CYCLES = 4;
  localparam logic [15:0] BOOT_BASE = 16'h8000;
  localparam int BOOT_DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rnw = 1'b1;
  logic        cpu_clk, cpu_rdata_oe, ram_sel, glue_en;
  logic [7:0]  cpu_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic       oe;
    logic [7:0] data;
    logic       sel;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsc_boot_shadow #(.RUN_DIV(RUN_DIV), .HOLD_CYCLES(HOLD_CYCLES)) i_bsc_boot_shadow (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
    .cpu_clk(cpu_clk), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .ram_sel(ram_sel), .glue_en(glue_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_boot(input int k);
    return 8'((k * 37 + 90) % 256);
  endfunction

  function automatic logic [7:0] exp_mon(input logic [15:0] a);
    if (a == 16'hFFFC) return BOOT_BASE[7:0];
    if (a == 16'hFFFD) return BOOT_BASE[15:8];
    return a[7:0] ^ a[15:8];
  endfunction

  // Monitor: pops one expected item per transfer and compares the bus outputs.
  always begin
    @(mon_ev);
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(cpu_clk === 1'b1, {e.tag, " high phase"}, int'(cpu_clk), 1);
      chk(cpu_rdata_oe === e.oe, {e.tag, " oe"}, int'(cpu_rdata_oe), int'(e.oe));
      chk(ram_sel === e.sel, {e.tag, " ram_sel"}, int'(ram_sel), int'(e.sel));
      if (e.oe)
        chk(cpu_rdata === e.data, {e.tag, " data"}, int'(cpu_rdata), int'(e.data));
    end
  end

  // Driver: places the address during a low phase, samples in the high phase.
  task automatic bus(input logic [15:0] a, input logic rnw,
                     input logic eoe, input logic [7:0] ed, input logic esel,
                     input string tag);
    exp_t e;
    do @(negedge clk); while (cpu_clk !== 1'b0);
    cpu_addr = a;
    cpu_rnw  = rnw;
    do @(negedge clk); while (cpu_clk !== 1'b1);
    e.oe = eoe; e.data = ed; e.sel = esel; e.tag = tag;
    exp_q.push_back(e);
    -> mon_ev;
  endtask

  task automatic check_hold(input string tag);
    for (int i = 0; i < HOLD_CYCLES; i++) begin
      @(negedge clk);
      chk(cpu_clk === 1'b0 && glue_en === 1'b0 && cpu_rdata_oe === 1'b0 && ram_sel === 1'b0,
          tag, int'(cpu_clk), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state and hold window
    repeat (3) @(negedge clk);
    chk(cpu_clk === 1'b0 && glue_en === 1'b0 && cpu_rdata_oe === 1'b0 && ram_sel === 1'b0,
        "R1 in reset", int'(glue_en), 0);
    rst_n = 1'b1;
    check_hold("R1 hold window");
    @(negedge clk);
    chk(cpu_clk === 1'b1, "R2 first boot phase", int'(cpu_clk), 1);
    @(negedge clk);
    chk(cpu_clk === 1'b0, "R2 boot toggle", int'(cpu_clk), 0);
    @(negedge clk);
    chk(cpu_clk === 1'b1, "R2 boot toggle again", int'(cpu_clk), 1);

    // R4: reset vector and monitor image reads
    bus(16'hFFFC, 1'b1, 1'b1, exp_mon(16'hFFFC), 1'b0, "R4 vector lo");
    bus(16'hFFFD, 1'b1, 1'b1, exp_mon(16'hFFFD), 1'b0, "R4 vector hi");
    bus(16'hE800, 1'b1, 1'b1, exp_mon(16'hE800), 1'b0, "R4 rom base");
    bus(16'hE9AB, 1'b1, 1'b1, exp_mon(16'hE9AB), 1'b0, "R4 rom mid");
    bus(16'hFFFF, 1'b1, 1'b1, exp_mon(16'hFFFF), 1'b0, "R4 rom top");

    // R3: bootstrap window reads
    bus(BOOT_BASE, 1'b1, 1'b1, exp_boot(0), 1'b0, "R3 boot first");
    bus(BOOT_BASE + 16'd5, 1'b1, 1'b1, exp_boot(5), 1'b0, "R3 boot mid");
    bus(BOOT_BASE + 16'(BOOT_DEPTH - 1), 1'b1, 1'b1, exp_boot(BOOT_DEPTH - 1), 1'b0,
        "R3 boot last");

    // R5: filler elsewhere
    bus(BOOT_BASE + 16'(BOOT_DEPTH), 1'b1, 1'b1, 8'hEA, 1'b0, "R5 past boot window");
    bus(16'h1234, 1'b1, 1'b1, 8'hEA, 1'b0, "R5 low memory");
    bus(16'hE7FF, 1'b1, 1'b1, 8'hEA, 1'b0, "R5 below rom");
    bus(16'h7FFF, 1'b1, 1'b1, 8'hEA, 1'b0, "R5 below boot window");

    // R6: writes
    bus(16'hE800, 1'b0, 1'b0, 8'h00, 1'b1, "R6 write rom base");
    bus(16'hFFFF, 1'b0, 1'b0, 8'h00, 1'b1, "R6 write rom top");
    bus(16'hE7FF, 1'b0, 1'b0, 8'h00, 1'b0, "R6 write below rom");
    bus(16'h0200, 1'b0, 1'b0, 8'h00, 1'b0, "R6 write low memory");

    // R7: premature finish marker is ignored
    bus(16'h8889, 1'b0, 1'b0, 8'h00, 1'b0, "R7 early finish");
    @(negedge clk);
    chk(glue_en === 1'b0, "R7 glue after early finish", int'(glue_en), 0);
    bus(16'hE801, 1'b1, 1'b1, exp_mon(16'hE801), 1'b0, "R7 still booting");

    // R8: start then finish hands the bus over
    bus(16'h8888, 1'b0, 1'b0, 8'h00, 1'b0, "R8 start marker");
    @(negedge clk);
    chk(glue_en === 1'b0, "R8 glue after start only", int'(glue_en), 0);
    bus(16'h8889, 1'b0, 1'b0, 8'h00, 1'b0, "R8 finish marker");
    chk(glue_en === 1'b0, "R8 glue during finish phase", int'(glue_en), 0);
    @(negedge clk);
    chk(glue_en === 1'b1, "R8 glue after finish", int'(glue_en), 1);

    // R9: run mode leaves data and RAM select alone
    cpu_addr = 16'hE800; cpu_rnw = 1'b1;
    for (int i = 0; i < 2 * RUN_DIV + 1; i++) begin
      @(negedge clk);
      chk(cpu_rdata_oe === 1'b0 && ram_sel === 1'b0, "R9 run read", int'(cpu_rdata_oe), 0);
    end
    cpu_rnw = 1'b0;
    for (int i = 0; i < 2 * RUN_DIV + 1; i++) begin
      @(negedge clk);
      chk(ram_sel === 1'b0 && cpu_rdata_oe === 1'b0, "R9 run write", int'(ram_sel), 0);
    end

    // R10: free-running divided clock
    begin
      logic cur;
      int n;
      cur = cpu_clk;
      n = 0;
      do begin @(negedge clk); n++; end while (cpu_clk === cur && n < 100);
      for (int p = 0; p < 6; p++) begin
        cur = cpu_clk;
        n = 0;
        do begin @(negedge clk); n++; end while (cpu_clk === cur && n < 100);
        chk(n == RUN_DIV, "R10 run phase length", n, RUN_DIV);
      end
    end

    // R8: sticky through further marker writes
    cpu_addr = 16'h8888; cpu_rnw = 1'b0;
    repeat (2 * RUN_DIV) @(negedge clk);
    cpu_addr = 16'h8889;
    repeat (2 * RUN_DIV) @(negedge clk);
    chk(glue_en === 1'b1, "R8 glue sticky", int'(glue_en), 1);

    // R11: reset from run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(glue_en === 1'b0 && cpu_clk === 1'b0, "R11 async drop", int'(glue_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cpu_addr = 16'h0000; cpu_rnw = 1'b1;
    check_hold("R11 hold after reset");
    bus(16'hFFFD, 1'b1, 1'b1, exp_mon(16'hFFFD), 1'b0, "R11 boot again");
    @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule